// File: doc/BRIEF.md
# Peripheral Interrupt Pending and Enable Logic

This block keeps the interrupt status of a display-timing peripheral that has four event sources. Each source delivers a one-cycle strobe. The strobe sets a sticky pending bit, and that bit stays set until the host clears it. The host reaches the block through a small register port. One register holds the pending bits, which the host reads and clears by writing ones. The other register holds the enable bits, which the host reads and writes.

The block drives a single level-sensitive request toward the system interrupt controller. The request is the registered OR of the bits that are both pending and enabled. It therefore stays high until every enabled source has been serviced. There is no separate acknowledge: the host drops the request by clearing the pending bit or by disabling the source.

Sources that are disabled still record their pending bits. This lets the host run the block purely by polling, with every enable cleared.

Top module: `irq_pend_ctrl`

## Requirements
- R1: Strobe bit i sets pending bit i, with bit 0 = line start, bit 1 = line end, bit 2 = frame start and bit 3 = frame end. The set bit is readable from the cycle after the strobe.
- R2: A write to the pending register (wr_sel = 0) clears every bit written as 1. Bits written as 0 keep their value.
- R3: When a strobe and a clear reach the same pending bit in the same cycle, the bit ends up set.
- R4: The irq output goes high one cycle after any bit is both pending and enabled, and it holds the registered OR of (enable AND pending).
- R5: While the enable register is all zero, irq stays low, but strobes still set pending bits for polling.
- R6: A strobe on a disabled source records its pending bit without changing irq.
- R7: Once high, irq stays high until the host clears the enabled pending bits or disables them. No other action lowers it.
- R8: Register select 0 is the pending register (read, write-one-to-clear) and select 1 is the enable register (read/write). Reads are combinational and show the value registered before any same-cycle update.
- R9: After reset, both registers read zero and irq is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NSRC | One-cycle event strobes, one per source |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 pending, 1 enable |
| wr_data | input | NSRC | Write data |
| rd_sel | input | 1 | Read target: 0 pending, 1 enable |
| rd_data | output | NSRC | Read data |
| irq | output | 1 | Level interrupt request |

## Verification
A corrupted pending bit appears on rd_data in the cycle after the faulty edge, whenever pending is selected. It reaches irq one cycle later if that bit is enabled. A wrong enable bit shows up either on a readback with select 1, or as an irq that rises or falls one cycle off from the expected point. The hazards that matter most are a strobe lost to a coincident clear, and a request that drops without service. Both are exercised directly and under random traffic, and the model is compared on every cycle.

// File: rtl/irq_pend_ctrl.sv
`timescale 1ns/1ps
module irq_pend_ctrl #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic            wr_en,
  input  logic            wr_sel,
  input  logic [NSRC-1:0] wr_data,
  input  logic            rd_sel,
  output logic [NSRC-1:0] rd_data,
  output logic            irq
);
  localparam logic SEL_PEND = 1'b0;
  localparam logic SEL_EN   = 1'b1;

  logic [NSRC-1:0] pend_q, en_q, clr;

  assign clr     = (wr_en && wr_sel == SEL_PEND) ? wr_data : '0;
  assign rd_data = (rd_sel == SEL_EN) ? en_q : pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      irq    <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~clr) | evt_i;
      if (wr_en && wr_sel == SEL_EN) en_q <= wr_data;
      irq <= |(pend_q & en_q);
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_bit_chk
    // R3
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[i] |=> pend_q[i]);
    // R2
    w0_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[i] && !clr[i]) |=> pend_q[i]);
    // R2
    w1_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !evt_i[i]) |=> !pend_q[i]);
  end

  // R5
  no_irq_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |=> !irq);
  // R4
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(pend_q != '0));
  // R7
  irq_fall_serviced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_en, 2));
endmodule

// File: tb/irq_pend_ctrl_bench.sv
`timescale 1ns/1ps
module irq_pend_ctrl_bench;
  logic clk = 0, rst_n = 0;
  logic [3:0] evt = 0, wr_data = 0, rd_data;
  logic wr_en = 0, wr_sel = 0, rd_sel = 0, irq;
  logic [3:0] m_pend = 0, m_en = 0;
  logic m_irq = 0;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  irq_pend_ctrl #(.NSRC(4)) u_irq_pend_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq));

  function automatic logic [3:0] nxt_pend(logic [3:0] p, logic [3:0] e, logic [3:0] c);
    return (p & ~c) | e;
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] e, input logic we, input logic ws,
                      input logic [3:0] wd, input logic rs, input string tag);
    @(negedge clk);
    evt = e; wr_en = we; wr_sel = ws; wr_data = wd; rd_sel = rs;
    @(posedge clk);
    m_irq  = |(m_pend & m_en);
    m_pend = nxt_pend(m_pend, e, (we && !ws) ? wd : 4'h0);
    if (we && ws) m_en = wd;
    #2;
    chk({tag, " rd"}, rd_data, rs ? m_en : m_pend);
    chk({tag, " irq"}, {3'b0, irq}, {3'b0, m_irq});
  endtask

  task automatic idle(input logic rs, input string tag);
    step(4'h0, 1'b0, 1'b0, 4'h0, rs, tag);
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R9 R8 reset state
    #1; chk("R9 pend", rd_data, 4'h0); chk("R9 irq", {3'b0, irq}, 4'h0);
    idle(1'b1, "R9 en");
    // R1 bit mapping, one source at a time
    for (int i = 0; i < 4; i++) begin
      step(4'h1 << i, 1'b0, 1'b0, 4'h0, 1'b0, "R1 set");
      chk("R1 map", rd_data, 4'h1 << i);
      step(4'h0, 1'b1, 1'b0, 4'hF, 1'b0, "R2 clr");
    end
    // R5 polled operation
    step(4'hF, 1'b0, 1'b0, 4'h0, 1'b0, "R5 strobe");
    repeat (3) idle(1'b0, "R5 poll");
    chk("R5 irq low", {3'b0, irq}, 4'h0);
    // R2 partial clear and zero write
    step(4'h0, 1'b1, 1'b0, 4'h5, 1'b0, "R2 w1c");
    chk("R2 partial", rd_data, 4'hA);
    step(4'h0, 1'b1, 1'b0, 4'h0, 1'b0, "R2 w0");
    chk("R2 w0 keeps", rd_data, 4'hA);
    // R3 set wins
    step(4'h2, 1'b1, 1'b0, 4'h2, 1'b0, "R3 collide");
    chk("R3 set wins", rd_data & 4'h2, 4'h2);
    step(4'h0, 1'b1, 1'b0, 4'hF, 1'b0, "R2 clr all");
    // R4 latency
    step(4'h0, 1'b1, 1'b1, 4'h4, 1'b1, "R8 en wr");
    chk("R8 en read", rd_data, 4'h4);
    step(4'h4, 1'b0, 1'b0, 4'h0, 1'b0, "R4 strobe");
    chk("R4 not yet", {3'b0, irq}, 4'h0);
    idle(1'b0, "R4 rise");
    chk("R4 high", {3'b0, irq}, 4'h1);
    // R6 disabled source
    step(4'h1, 1'b0, 1'b0, 4'h0, 1'b0, "R6 strobe");
    chk("R6 recorded", rd_data, 4'h5);
    // R7 hold then service
    step(4'h0, 1'b1, 1'b0, 4'h1, 1'b0, "R7 clr other");
    idle(1'b0, "R7 hold");
    chk("R7 held", {3'b0, irq}, 4'h1);
    step(4'h0, 1'b1, 1'b1, 4'h0, 1'b0, "R7 disable");
    idle(1'b0, "R7 drop");
    chk("R7 dropped", {3'b0, irq}, 4'h0);
    step(4'h0, 1'b1, 1'b1, 4'h4, 1'b0, "R7 reenable");
    idle(1'b0, "R7 again");
    chk("R7 again high", {3'b0, irq}, 4'h1);
    step(4'h0, 1'b1, 1'b0, 4'h4, 1'b0, "R7 clear");
    idle(1'b0, "R7 clear drop");
    chk("R7 clear drop", {3'b0, irq}, 4'h0);
    // R4 R8 random traffic
    for (int n = 0; n < 600; n++) begin
      logic [3:0] e;
      logic we;
      e  = ($urandom % 3 == 0) ? 4'($urandom) : 4'h0;
      we = ($urandom % 4 == 0);
      step(e, we, 1'($urandom), 4'($urandom), 1'($urandom), "R4 R8 random");
    end
    idle(1'b0, "R8 final");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule